// File: doc/BRIEF.md
# I2C Bit-Rate and SDA-Timing Generator

This block sits between the peripheral clock and the bit engine of an I2C master. It takes a rate setting from a control word, a prescaler of 16 or 256 and a 4-bit divider, and from it produces a strobe every quarter of an SCL period. It also gives the phase index that the strobe announces and an SCL level derived from that phase. The bit engine changes SDA while SCL is low (phases 0 and 1) and samples it while SCL is high (phases 2 and 3). The SCL frequency is pclk / (prescale × (N+1)).

On the data line the block does two things. First, it holds back each change of the SDA drive value by 0, 5, 10 or 15 clocks, chosen by a line-control word, so that SDA moves a set time after the SCL edge. Second, it can pass the incoming SDA level through a glitch filter that accepts a new level only once that level has held for three consecutive clock samples.

When the prescaler or divider field is rewritten, the counters restart at once. The first quarter at the new rate is therefore full length.

Top module: `i2c_rate_timing`

## Requirements
- R1: Bit 6 of `ctrlWord` selects the prescale: 0 means 16 and 1 means 256. Bits 7, 5 and 4 of `ctrlWord` have no effect on any output.
- R2: Bits 3:0 of `ctrlWord` hold N. While the configuration is constant, successive `phaseStrobe` pulses are exactly prescale×(N+1)/4 clocks apart, and each pulse lasts one cycle.
- R3: Each `phaseStrobe` pulse advances `phaseIdx` by one, modulo 4, and `phaseIdx` does not change between pulses. `sclOut` is 0 in phases 0 and 1 and 1 in phases 2 and 3, so one SCL period lasts prescale×(N+1) clocks.
- R4: After reset, `phaseStrobe` is 0, `phaseIdx` is 3, `sclOut` is 1 and the filtered SDA level is 1.
- R5: A clock edge that sees a changed prescale bit or divider field restarts the counters and sets `phaseIdx` to 3. The next strobe comes exactly one new quarter period after that edge, and it shows phase 0. Writing only the ignored control bits causes no restart.
- R6: `lineCtrl[1:0]` = D, with D from 1 to 3, makes `sdaDriveOut` equal to `sdaDriveIn` as it was 5×D clock edges earlier.
- R7: With D = 0, `sdaDriveOut` follows `sdaDriveIn` in the same cycle, with no register in the path.
- R8: With `lineCtrl[2]` = 1, `sdaFiltOut` takes a new pad level at the third consecutive rising edge at which `sdaPadIn` holds that level. Pulses of one or two cycles are rejected.
- R9: With `lineCtrl[2]` = 0, `sdaFiltOut` follows `sdaPadIn` combinationally.
- R10: Bits 7:3 of `lineCtrl` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWord | input | 8 | Rate control: bit 6 prescale select, bits 3:0 divider N |
| lineCtrl | input | 8 | Line control: bits 1:0 SDA delay in steps of 5 clocks, bit 2 filter enable |
| sdaDriveIn | input | 1 | SDA value requested by the bit engine |
| sdaPadIn | input | 1 | Raw SDA level from the pad |
| phaseStrobe | output | 1 | One-cycle pulse at every quarter of the SCL period |
| phaseIdx | output | 2 | Phase announced by the latest strobe |
| sclOut | output | 1 | SCL level derived from the phase |
| sdaDriveOut | output | 1 | Delayed SDA drive value |
| sdaFiltOut | output | 1 | Filtered (or raw) SDA input level |

## Verification
The bench sweeps all 32 rate settings. For each one it counts the clocks from the reconfiguring edge to the first strobe and between the strobes that follow. An off-by-one in the divider terminal, or a reload that keeps the old prescale count, shows up as a quarter that is one clock short or long, or as a first quarter that is only partial. It also changes the divider in the middle of a period and toggles only the ignored control bits. A design that reloads on any write, or never reloads, gives a strobe in the wrong cycle. For every delay setting the bench samples the SDA drive value edge by edge after a toggle, which catches a tap that is off by one step. For the filter, low pulses of one to four cycles tell apart a filter that is two samples deep, one that is four samples deep, and one that never releases.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
  // strobes handed from the rate control to the datapath
  typedef struct packed {
    logic reload;   // configuration rewritten this cycle
    logic quarter;  // quarter period completes at this edge
  } rateStrobe_t;
endpackage

// File: rtl/rt_rate_ctrl.sv
module rt_rate_ctrl
  import i2c_rt_pkg::*;
#(
  parameter int PRESC_LO = 16,
  parameter int PRESC_HI = 256,
  parameter int DIV_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prescSel,
  input  logic [DIV_W-1:0] divVal,
  output rateStrobe_t      strb
);
  localparam int QLO  = PRESC_LO / 4;
  localparam int QHI  = PRESC_HI / 4;
  localparam int PC_W = $clog2(QHI);

  logic             prevSel;
  logic [DIV_W-1:0] prevDiv;
  logic [PC_W-1:0]  preCnt;
  logic [DIV_W-1:0] divCnt;
  logic             cfgChange;
  logic             preLast;
  logic             divLast;

  always_comb begin
    cfgChange = (prescSel != prevSel) || (divVal != prevDiv);
    preLast   = (preCnt == (prevSel ? PC_W'(QHI - 1) : PC_W'(QLO - 1)));
    divLast   = (divCnt == prevDiv);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= 1'b0;
      prevDiv <= '0;
      preCnt  <= '0;
      divCnt  <= '0;
    end else begin
      prevSel <= prescSel;
      prevDiv <= divVal;
      if (cfgChange) begin
        preCnt <= '0;
        divCnt <= '0;
      end else if (preLast) begin
        preCnt <= '0;
        divCnt <= divLast ? '0 : divCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign strb.reload  = cfgChange;
  assign strb.quarter = preLast && divLast && !cfgChange;
endmodule

// File: rtl/rt_sda_path.sv
module rt_sda_path
  import i2c_rt_pkg::*;
#(
  parameter int DLY_STEP = 5,
  parameter int DLY_W    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  rateStrobe_t      strb,
  input  logic [DLY_W-1:0] dlySel,
  input  logic             filtEn,
  input  logic             sdaDriveIn,
  input  logic             sdaPadIn,
  output logic             phaseStrobe,
  output logic [1:0]       phaseIdx,
  output logic             sdaDriveOut,
  output logic             sdaFiltOut
);
  localparam int NTAP    = 1 << DLY_W;
  localparam int DLY_MAX = DLY_STEP * (NTAP - 1);
  localparam int HIST    = FILT_LEN - 1;

  // phase sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseStrobe <= 1'b0;
      phaseIdx    <= 2'd3;
    end else begin
      phaseStrobe <= strb.quarter;
      if (strb.reload)       phaseIdx <= 2'd3;
      else if (strb.quarter) phaseIdx <= phaseIdx + 2'd1;
    end
  end

  // SDA output delay line with taps every DLY_STEP clocks
  logic [DLY_MAX-1:0] dlyLine;
  logic               tapVal [NTAP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyLine <= '1;
    else       dlyLine <= {dlyLine[DLY_MAX-2:0], sdaDriveIn};
  end

  assign tapVal[0] = sdaDriveIn;
  for (genvar t = 1; t < NTAP; t++) begin : g_tap
    assign tapVal[t] = dlyLine[DLY_STEP*t-1];
  end
  assign sdaDriveOut = tapVal[dlySel];

  // SDA input glitch filter
  logic [HIST-1:0] filtHist;
  logic            filtLvl;
  logic            allMatch;

  always_comb allMatch = (filtHist == {HIST{sdaPadIn}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtHist <= '1;
      filtLvl  <= 1'b1;
    end else begin
      if (HIST > 1) filtHist <= {filtHist, sdaPadIn};
      else          filtHist <= HIST'(sdaPadIn);
      if (allMatch) filtLvl <= sdaPadIn;
    end
  end

  assign sdaFiltOut = filtEn ? filtLvl : sdaPadIn;
endmodule

// File: rtl/i2c_rate_timing.sv
module i2c_rate_timing
  import i2c_rt_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int PRESC_LO = 16,
  parameter int PRESC_HI = 256,
  parameter int DIV_W    = 4,
  parameter int PSEL_BIT = 6,
  parameter int DLY_STEP = 5,
  parameter int DLY_W    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [CTRL_W-1:0] lineCtrl,
  input  logic              sdaDriveIn,
  input  logic              sdaPadIn,
  output logic              phaseStrobe,
  output logic [1:0]        phaseIdx,
  output logic              sclOut,
  output logic              sdaDriveOut,
  output logic              sdaFiltOut
);
  rateStrobe_t strb;

  rt_rate_ctrl #(
    .PRESC_LO(PRESC_LO), .PRESC_HI(PRESC_HI), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .prescSel (ctrlWord[PSEL_BIT]),
    .divVal   (ctrlWord[DIV_W-1:0]),
    .strb     (strb)
  );

  rt_sda_path #(
    .DLY_STEP(DLY_STEP), .DLY_W(DLY_W), .FILT_LEN(FILT_LEN)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dlySel      (lineCtrl[DLY_W-1:0]),
    .filtEn      (lineCtrl[DLY_W]),
    .sdaDriveIn  (sdaDriveIn),
    .sdaPadIn    (sdaPadIn),
    .phaseStrobe (phaseStrobe),
    .phaseIdx    (phaseIdx),
    .sdaDriveOut (sdaDriveOut),
    .sdaFiltOut  (sdaFiltOut)
  );

  assign sclOut = phaseIdx[1];
endmodule

// File: rtl/i2c_rate_timing_chk.sv
module i2c_rate_timing_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlWord,
  input logic [7:0] lineCtrl,
  input logic       sdaDriveIn,
  input logic       sdaPadIn,
  input logic       phaseStrobe,
  input logic [1:0] phaseIdx,
  input logic       sclOut,
  input logic       sdaDriveOut,
  input logic       sdaFiltOut
);
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    phaseStrobe |=> !phaseStrobe); // R2

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    phaseStrobe |-> phaseIdx == 2'($past(phaseIdx) + 2'd1)); // R3

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseStrobe && phaseIdx != 2'd3) |-> $stable(phaseIdx)); // R3

  AST_NO_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (lineCtrl[1:0] == 2'd0) |-> sdaDriveOut == sdaDriveIn); // R7

  AST_DELAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6 && lineCtrl[1:0] == 2'd1 && $past(lineCtrl[1:0], 5) == 2'd1)
      |-> sdaDriveOut == $past(sdaDriveIn, 5)); // R6

  AST_FILTER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4 && lineCtrl[2] && $past(lineCtrl[2]) && sdaFiltOut != $past(sdaFiltOut))
      |-> ($past(sdaPadIn) == sdaFiltOut && $past(sdaPadIn, 2) == sdaFiltOut
           && $past(sdaPadIn, 3) == sdaFiltOut)); // R8

  AST_FILTER_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    !lineCtrl[2] |-> sdaFiltOut == sdaPadIn); // R9
endmodule

bind i2c_rate_timing i2c_rate_timing_chk u_chk (.*);

// File: tb/test_i2c_rate_timing.sv
module test_i2c_rate_timing;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ctrlWord = 8'h4F;
  logic [7:0] lineCtrl = 8'h00;
  logic       sdaDriveIn = 1'b1;
  logic       sdaPadIn = 1'b1;
  logic       phaseStrobe;
  logic [1:0] phaseIdx;
  logic       sclOut;
  logic       sdaDriveOut;
  logic       sdaFiltOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  i2c_rate_timing i_i2c_rate_timing (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStrobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!phaseStrobe && n < 3000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R4 reset state
    chk(phaseStrobe == 1'b0, "R4 strobe", phaseStrobe, 0);
    chk(phaseIdx == 2'd3, "R4 phase", phaseIdx, 3);
    chk(sclOut == 1'b1, "R4 scl", sclOut, 1);
    lineCtrl = 8'h04;
    #1 chk(sdaFiltOut == 1'b1, "R4 filter level", sdaFiltOut, 1);
    rstN = 1'b1;

    // R1 R2 R3 R5: full sweep of prescale and divider
    for (int p = 0; p < 2; p++) begin
      for (int nDiv = 0; nDiv < 16; nDiv++) begin
        int q;
        q = (p ? 256 : 16) * (nDiv + 1) / 4;
        @(negedge clk);
        ctrlWord = {1'b0, p[0], 2'b00, nDiv[3:0]} | ((nDiv % 3 == 0) ? 8'hB0 : 8'h00);
        waitStrobe(n);
        chk(n == q + 1, "R5 first quarter after reload", n, q + 1);
        chk(phaseIdx == 2'd0 && sclOut == 1'b0, "R3 phase 0", phaseIdx, 0);
        for (int ph = 1; ph < 4; ph++) begin
          waitStrobe(n);
          chk(n == q, "R2 quarter length", n, q);
          chk(phaseIdx == ph[1:0], "R3 phase step", phaseIdx, ph);
          chk(sclOut == (ph >= 2), "R3 scl level", sclOut, ph >= 2);
        end
      end
    end

    // R5: mid-period divider change
    @(negedge clk);
    ctrlWord = 8'h03;
    waitStrobe(n);
    waitStrobe(n);
    repeat (5) @(negedge clk);
    ctrlWord = 8'h01;
    waitStrobe(n);
    chk(n == 9, "R5 mid-period reload", n, 9);
    chk(phaseIdx == 2'd0, "R5 phase after reload", phaseIdx, 0);

    // R1: ignored control bits cause no reload
    waitStrobe(n);
    repeat (3) @(negedge clk);
    ctrlWord = 8'hB1;
    waitStrobe(n);
    chk(n == 5, "R1 ignored bits keep period", n, 5);
    chk(phaseIdx == 2'd2, "R1 ignored bits keep phase", phaseIdx, 2);

    // R6 R7 R10: SDA output delay per setting, junk in upper bits
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      lineCtrl = {5'b10101, 1'b0, d[1:0]};
      for (int tg = 0; tg < 2; tg++) begin
        bit v;
        repeat (20) @(negedge clk);
        v = ~sdaDriveIn;
        sdaDriveIn = v;
        #1;
        if (d == 0) chk(sdaDriveOut == v, "R7 no delay passthrough", sdaDriveOut, v);
        for (int k = 1; k <= 18; k++) begin
          bit e;
          @(negedge clk);
          e = (k >= 5 * d) ? v : ~v;
          chk(sdaDriveOut == e, (d == 0) ? "R7 zero delay" : "R6 R10 delay tap", sdaDriveOut, e);
        end
      end
    end

    // R8: glitch filter with low pulses of 1..4 cycles
    @(negedge clk);
    lineCtrl = 8'hFC;
    sdaPadIn = 1'b1;
    for (int len = 1; len <= 4; len++) begin
      repeat (6) @(negedge clk);
      sdaPadIn = 1'b0;
      for (int k = 1; k <= len + 6; k++) begin
        bit e;
        @(negedge clk);
        e = !(len >= 3 && k >= 3 && k <= len + 2);
        chk(sdaFiltOut == e, "R8 filter", sdaFiltOut, e);
        if (k == len) sdaPadIn = 1'b1;
      end
    end

    // R9 R10: filter disabled, upper bits set
    @(negedge clk);
    lineCtrl = 8'hF8;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sdaPadIn = ~sdaPadIn;
      #1 chk(sdaFiltOut == sdaPadIn, "R9 R10 filter bypass", sdaFiltOut, sdaPadIn);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule